// File: doc/BRIEF.md
# TDC Fine-Bin Calibrator

A delay-line time-to-digital converter produces fine-bin codes whose bins are not all the same width. The widths also drift with supply and temperature. This block turns each raw code into a time in picoseconds by looking it up in a table. It rebuilds that table from the hits themselves. Every accepted code is counted into a per-bin histogram. Once a fixed window of hits has been counted, each bin's width is taken to be proportional to its count, and the table is rewritten so that each code maps to the centre of its bin.

The table has two banks. Lookups read the active bank while the next table is written into the idle one, so conversion never stops. The banks swap when the rebuild finishes, and the histogram then starts the next window from zero. Until the first rebuild, both banks hold a mapping that assumes every bin has the same width. The block does not remove very wide bins; it only gives them correct centre times. The coarse counter, the delay chain and any multi-edge correction are handled outside this block.

Top module: `tdc_bin_calibrator`

## Requirements
- R1: `out_valid` is high exactly in the cycle after `hit_valid` was sampled high. `out_ps` then holds the active table entry for the sampled `hit_code`. After reset, `out_valid` and `out_ps` are 0.
- R2: After reset, the entry for code k is ((2k+1)·CLK_PS) >> (log2(NBINS)+1). This is the centre of k when all bins have equal width.
- R3: A rebuild starts after 2^EVT_LOG2 histogram-counted hits. The new table is used for every hit sampled NBINS+1 or more cycles after the hit that closed the window.
- R4: The rebuilt entry for code k is ((2·S_k + c_k)·CLK_PS) >> (EVT_LOG2+1). Here c_k is the clipped count of bin k and S_k is the sum of c_0..c_{k-1}. Every output value is at most CLK_PS.
- R5: Hits sampled while a rebuild is in progress are converted with the table that was active before the rebuild.
- R6: Hits sampled while a rebuild is in progress are not counted into the histogram or the event window.
- R7: The histogram is cleared when the tables swap. The next table therefore depends only on hits counted after that swap.
- R8: A bin count saturates at 2^CNT_W−1 and does not wrap.
- R9: While `hit_valid` is low, `out_ps` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_valid | input | 1 | A raw code is present this cycle |
| hit_code | input | log2(NBINS) | Raw fine-bin code |
| out_valid | output | 1 | Converted time is valid |
| out_ps | output | OUT_W | Bin-centre time in picoseconds |

## Verification
The bench builds the block with 8 bins, a 64-hit window and 5-bit counters at a period of 2500 ps. With these values a full window, the rebuild and a probe of every code take only a few hundred cycles, so the bench can check every table entry after each of several differently skewed windows. Because a single bin can receive more hits than a 5-bit counter holds, saturation can be reached. Probes placed inside the 8-cycle rebuild test the old-table lookup and confirm that those hits are not counted.

// File: rtl/tdc_cal_pkg.sv
// Shared types and helpers for the TDC bin calibrator.
// Assumes bin counts are powers of two.
package tdc_cal_pkg;

    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_BUILD = 1'b1
    } build_state_t;

    // Centre of bin k when all 2^bin_w bins share one clock period equally.
    function automatic int unsigned uniform_center(int unsigned k,
                                                   int unsigned clk_ps,
                                                   int unsigned bin_w);
        return ((2 * k + 1) * clk_ps) >> (bin_w + 1);
    endfunction

endpackage

// File: rtl/tdc_cal_hist.sv
// Code-density histogram: one saturating counter per fine bin.
// Assumes inc and clr are never high in the same cycle; clr wins if they are.
module tdc_cal_hist #(
    parameter int NBINS = 64,
    parameter int CNT_W = 15,
    localparam int BIN_W = $clog2(NBINS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             inc,
    input  logic [BIN_W-1:0]                 code,
    input  logic                             clr,
    output logic [NBINS-1:0][CNT_W-1:0]      counts
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count accepted hits per bin, clip at the top, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            counts <= '0;
        end else if (inc && counts[code] != CNT_MAX) begin
            counts[code] <= counts[code] + 1'b1;
        end
    end

endmodule

// File: rtl/tdc_cal_builder.sv
// Walks the histogram one bin per cycle and emits bin-centre table entries.
// entry_k = ((2*S_k + c_k) * CLK_PS) >> (EVT_LOG2+1), S_k = sum of earlier counts.
// Assumes start arrives only while idle; takes NBINS cycles per rebuild.
module tdc_cal_builder
    import tdc_cal_pkg::*;
#(
    parameter int NBINS    = 64,
    parameter int CNT_W    = 15,
    parameter int EVT_LOG2 = 14,
    parameter int CLK_PS   = 2500,
    parameter int OUT_W    = 12,
    localparam int BIN_W   = $clog2(NBINS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [NBINS-1:0][CNT_W-1:0] counts,
    output logic                        building,
    output logic                        wr_en,
    output logic [BIN_W-1:0]            wr_idx,
    output logic [OUT_W-1:0]            wr_data,
    output logic                        done
);

    localparam int ACC_W  = CNT_W + BIN_W;
    localparam int SUM_W  = ACC_W + 1;
    localparam int PS_W   = $clog2(CLK_PS + 1);
    localparam int PROD_W = SUM_W + PS_W;
    localparam int SHIFT  = EVT_LOG2 + 1;
    localparam logic [BIN_W-1:0] LAST_IDX = BIN_W'(NBINS - 1);

    build_state_t        state;
    logic [BIN_W-1:0]    idx;
    logic [ACC_W-1:0]    acc;
    logic [CNT_W-1:0]    cur_cnt;
    logic [SUM_W-1:0]    twice_mid;
    logic [PROD_W-1:0]   product;
    logic [PROD_W-1:0]   scaled;

    // Centre in count units doubled, then scaled to picoseconds.
    always_comb begin
        cur_cnt   = counts[idx];
        twice_mid = {acc, 1'b0} + SUM_W'(cur_cnt);
        product   = PROD_W'(twice_mid) * PROD_W'(CLK_PS);
        scaled    = product >> SHIFT;
    end

    assign building = (state == ST_BUILD);
    assign wr_en    = building;
    assign wr_idx   = idx;
    assign wr_data  = OUT_W'(scaled);
    assign done     = building && (idx == LAST_IDX);

    // Sequence the bin walk and carry the running count sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_COUNT;
            idx   <= '0;
            acc   <= '0;
        end else if (state == ST_COUNT) begin
            if (start) begin
                state <= ST_BUILD;
                idx   <= '0;
                acc   <= '0;
            end
        end else begin
            acc <= acc + ACC_W'(cur_cnt);
            idx <= idx + 1'b1;
            if (idx == LAST_IDX) begin
                state <= ST_COUNT;
            end
        end
    end

endmodule

// File: rtl/tdc_cal_lut.sv
// Two-bank code-to-picosecond table with a registered lookup.
// Lookups read the active bank, writes go to the idle bank, swap flips them.
// Both banks reset to the equal-width centre mapping.
module tdc_cal_lut
    import tdc_cal_pkg::*;
#(
    parameter int NBINS  = 64,
    parameter int CLK_PS = 2500,
    parameter int OUT_W  = 12,
    localparam int BIN_W = $clog2(NBINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [BIN_W-1:0] rd_code,
    input  logic             wr_en,
    input  logic [BIN_W-1:0] wr_idx,
    input  logic [OUT_W-1:0] wr_data,
    input  logic             swap,
    output logic             bank_sel,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_ps
);

    logic [OUT_W-1:0] bank0 [NBINS];
    logic [OUT_W-1:0] bank1 [NBINS];

    // Load the default mapping, then accept writes into the idle bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NBINS; k++) begin
                bank0[k] <= OUT_W'(uniform_center(k, CLK_PS, BIN_W));
                bank1[k] <= OUT_W'(uniform_center(k, CLK_PS, BIN_W));
            end
        end else if (wr_en) begin
            if (bank_sel) bank0[wr_idx] <= wr_data;
            else          bank1[wr_idx] <= wr_data;
        end
    end

    // Flip the active bank when a rebuild completes.
    always_ff @(posedge clk) begin
        if (!rst_n)    bank_sel <= 1'b0;
        else if (swap) bank_sel <= ~bank_sel;
    end

    // Registered lookup from the active bank; value held between hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ps    <= '0;
        end else begin
            out_valid <= rd_en;
            if (rd_en) out_ps <= bank_sel ? bank1[rd_code] : bank0[rd_code];
        end
    end

endmodule

// File: rtl/tdc_bin_calibrator.sv
// Top of the TDC bin calibrator: lookup, histogram, window counter, rebuild.
// Hits are always converted; they are counted only outside a rebuild.
// After 2^EVT_LOG2 counted hits the table is rebuilt over NBINS cycles,
// then the banks swap and the histogram clears.
module tdc_bin_calibrator #(
    parameter int NBINS    = 64,
    parameter int EVT_LOG2 = 14,
    parameter int CNT_W    = 15,
    parameter int CLK_PS   = 2500,
    parameter int OUT_W    = 12,
    localparam int BIN_W   = $clog2(NBINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_valid,
    input  logic [BIN_W-1:0] hit_code,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_ps
);

    logic                        building;
    logic                        accept;
    logic                        start;
    logic                        done;
    logic                        wr_en;
    logic [BIN_W-1:0]            wr_idx;
    logic [OUT_W-1:0]            wr_data;
    logic                        bank_sel;
    logic [EVT_LOG2-1:0]         win_cnt;
    logic [NBINS-1:0][CNT_W-1:0] counts;

    assign accept = hit_valid && !building;
    assign start  = accept && (&win_cnt);

    // Count hits in the current window; wrap to zero when it closes.
    always_ff @(posedge clk) begin
        if (!rst_n)      win_cnt <= '0;
        else if (accept) win_cnt <= win_cnt + 1'b1;
    end

    tdc_cal_hist #(
        .NBINS (NBINS),
        .CNT_W (CNT_W)
    ) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (accept),
        .code   (hit_code),
        .clr    (done),
        .counts (counts)
    );

    tdc_cal_builder #(
        .NBINS    (NBINS),
        .CNT_W    (CNT_W),
        .EVT_LOG2 (EVT_LOG2),
        .CLK_PS   (CLK_PS),
        .OUT_W    (OUT_W)
    ) u_builder (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .counts   (counts),
        .building (building),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .done     (done)
    );

    tdc_cal_lut #(
        .NBINS  (NBINS),
        .CLK_PS (CLK_PS),
        .OUT_W  (OUT_W)
    ) u_lut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (hit_valid),
        .rd_code   (hit_code),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .swap      (done),
        .bank_sel  (bank_sel),
        .out_valid (out_valid),
        .out_ps    (out_ps)
    );

endmodule

// File: rtl/tdc_cal_chk.sv
// Assertion checker for tdc_bin_calibrator, attached by bind below.
module tdc_cal_chk #(
    parameter int EVT_LOG2 = 14,
    parameter int CLK_PS   = 2500,
    parameter int OUT_W    = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                hit_valid,
    input logic                out_valid,
    input logic [OUT_W-1:0]    out_ps,
    input logic                bank_sel,
    input logic                building,
    input logic [EVT_LOG2-1:0] win_cnt
);

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(hit_valid)));

    // R9
    hold_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(hit_valid)) |-> $stable(out_ps));

    // R3
    swap_after_build_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(bank_sel)) |-> $past(building));

    // R6
    no_count_in_build_chk: assert property (@(posedge clk) disable iff (!rst_n)
        building |-> (win_cnt == '0));

    // R4
    out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (32'(out_ps) <= CLK_PS));

endmodule

bind tdc_bin_calibrator tdc_cal_chk #(
    .EVT_LOG2 (EVT_LOG2),
    .CLK_PS   (CLK_PS),
    .OUT_W    (OUT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_valid (hit_valid),
    .out_valid (out_valid),
    .out_ps    (out_ps),
    .bank_sel  (bank_sel),
    .building  (building),
    .win_cnt   (win_cnt)
);

// File: tb/test_tdc_bin_calibrator.sv
module test_tdc_bin_calibrator;

    localparam int NB  = 8;
    localparam int BW  = 3;
    localparam int L   = 6;
    localparam int CW  = 5;
    localparam int CK  = 2500;
    localparam int OW  = 12;
    localparam int WIN = 1 << L;
    localparam int SAT = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hit_valid = 1'b0;
    logic [BW-1:0] hit_code = '0;
    logic          out_valid;
    logic [OW-1:0] out_ps;

    always #2.5 clk = ~clk;

    tdc_bin_calibrator #(
        .NBINS (NB), .EVT_LOG2 (L), .CNT_W (CW), .CLK_PS (CK), .OUT_W (OW)
    ) i_tdc_bin_calibrator (
        .clk (clk), .rst_n (rst_n), .hit_valid (hit_valid),
        .hit_code (hit_code), .out_valid (out_valid), .out_ps (out_ps)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 0;
    int  hc  [NB];
    int  tbl [NB];
    int  nxt [NB];
    int  winc = 0;
    bit  pend = 0;
    int  last_exp = 0;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Model of histogram, window and rebuild arithmetic (R4, R8).
    function automatic void model_hit(int code, bit counted);
        longint s;
        if (!counted) return;
        if (hc[code] < SAT) hc[code]++;
        winc++;
        if (winc == WIN) begin
            s = 0;
            for (int k = 0; k < NB; k++) begin
                nxt[k] = int'(((2 * s + hc[k]) * CK) >> (L + 1));
                s += hc[k];
            end
            for (int k = 0; k < NB; k++) hc[k] = 0;
            winc = 0;
            pend = 1;
        end
    endfunction

    task automatic probe(int code, bit counted, string tag);
        int e;
        e = tbl[code];
        hit_valid = 1'b1;
        hit_code  = BW'(code);
        model_hit(code, counted);
        @(negedge clk);
        check(tag, int'(out_valid), 1);
        check(tag, int'(out_ps), e);
        last_exp = e;
    endtask

    task automatic fill(int code);
        hit_valid = 1'b1;
        hit_code  = BW'(code);
        model_hit(code, 1);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        hit_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic apply_new();
        if (pend) begin
            for (int k = 0; k < NB; k++) tbl[k] = nxt[k];
            pend = 0;
        end
    endtask

    task automatic probe_all(string tag);
        for (int k = 0; k < NB; k++) probe(k, 1, tag);
        idle(1);
    endtask

    initial begin
        for (int k = 0; k < NB; k++) begin
            hc[k]  = 0;
            tbl[k] = ((2 * k + 1) * CK) >> (BW + 1);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset value", int'(out_ps), 0);

        // R2 default equal-width table
        probe_all("R2");

        // Pattern A: skewed window, then probes during the rebuild
        while (winc != WIN - 1) fill((winc * winc + (winc >> 3)) % NB);
        fill(6);
        probe(7, 0, "R5");
        probe(2, 0, "R5");
        probe(5, 0, "R5");
        idle(NB + 4);
        check("R9 idle valid", int'(out_valid), 0);
        check("R9 hold", int'(out_ps), last_exp);
        apply_new();
        probe_all("R3 R4 R6");

        // Pattern B: one bin overfilled, counter clips
        while (winc != 0 || !pend) fill(3);
        idle(NB + 4);
        apply_new();
        probe_all("R8");

        // Pattern C: low bins favoured, histogram restarted from zero
        while (winc != 0 || !pend) fill(winc % 3);
        idle(NB + 4);
        apply_new();
        probe_all("R7");

        // Pattern D: only upper bins hit besides probes
        while (winc != 0 || !pend) fill(NB - 1 - (winc % 2));
        idle(NB + 4);
        apply_new();
        probe_all("R4 R7");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule